// File: doc/BRIEF.md
# Extension Enable Register with Write-Any-Read-Legal Policy

This block holds the machine-level register that tells the core which alphabetic instruction-set extensions are active. Bit n of the register stands for the letter 'A'+n. Software may write any value; the block corrects or discards combinations that are not legal, so a write never needs to trap. The two top bits carry a read-only code for the base register width.

The same block owns the exception return address register. While the compressed extension is switched off, the return address may only name 4-byte-aligned code, so bit 1 is dropped when stored and hidden when read. The return-address output feeds the trap-return path. A build-time parameter makes the extension register fully read-only.

Top module: `isa_cfg_csr`

## Requirements
- R1: After reset the extension register reads its reset value (default letters A, C, D, F, I, M, S, U: 0x4014112D with the width code) and the return address register reads 0.
- R2: Bit n of the extension register maps to letter 'A'+n (A=0, C=2, D=3, E=4, F=5, I=8, M=12); only bits set in the implemented mask (default 0x14113D) can be written, all other extension bits read 0, and an accepted write is visible from the next cycle.
- R3: Bits [XLEN-1:XLEN-2] always read the base-width code (1 for 32-bit) and bits [XLEN-3:26] read 0, whatever is written.
- R4: A write whose legalized value has neither I (bit 8) nor E (bit 4) set is dropped; the register keeps its old value.
- R5: When the legalized value has E (bit 4) set, F (bit 5) and D (bit 3) are forced to 0.
- R6: A write that would clear C (bit 2) while bit 1 of the next sequential instruction address is 1 leaves C at 1; the other bits of that write still apply.
- R7: A write to the return address register stores bit 0 as 0, and stores bit 1 as 0 while C is clear; with C set bit 1 is stored as written.
- R8: While C is clear, reads of the return address register and the return-target output show bit 1 as 0; setting C again shows the stored bit 1.
- R9: With the writable parameter at 0, writes to the extension register are ignored and it always reads its reset value.
- R10: Reads of any other address return 0, and writes to other addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address of the access |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write enable |
| csr_rdata | output | XLEN | Read data for csr_addr (combinational) |
| next_pc | input | XLEN | Address of the next sequential instruction |
| ret_target | output | XLEN | Legal return address for the trap-return path |

## Verification
On every cycle the assertions check that the register always holds I or E, never holds E together with F or D, keeps unimplemented bits and the width code fixed, refuses to drop C at a misaligned next address, and that the return target is aligned to 4 bytes while C is clear. Only the bench scenarios show the exact value a given write leaves behind, that a dropped write leaves every bit untouched, that a return address bit 1 stored while C was clear stays zero after C returns, and that the read-only variant ignores all writes.

// File: rtl/isa_cfg_pkg.sv
package isa_cfg_pkg;
  localparam int unsigned EXT_W = 26;

  localparam int unsigned LTR_A = 0;
  localparam int unsigned LTR_C = 2;
  localparam int unsigned LTR_D = 3;
  localparam int unsigned LTR_E = 4;
  localparam int unsigned LTR_F = 5;
  localparam int unsigned LTR_I = 8;
  localparam int unsigned LTR_M = 12;

  typedef logic [EXT_W-1:0] ext_vec_t;

  function automatic logic [1:0] width_code(input int unsigned xlen);
    if (xlen == 32)      return 2'd1;
    else if (xlen == 64) return 2'd2;
    else                 return 2'd3;
  endfunction
endpackage

// File: rtl/isa_ext_legalizer.sv
module isa_ext_legalizer
  import isa_cfg_pkg::*;
#(
  parameter ext_vec_t IMPL_MASK = 26'h14113D
) (
  input  ext_vec_t cur_ext,
  input  ext_vec_t req_ext,
  input  logic     npc_bit1,
  output ext_vec_t legal_ext,
  output logic     accept
);
  ext_vec_t masked;
  ext_vec_t no_fd;
  ext_vec_t c_fixed;

  assign masked = req_ext & IMPL_MASK;

  generate
    if (IMPL_MASK[LTR_E]) begin : g_e_rule
      always_comb begin
        no_fd = masked;
        if (masked[LTR_E]) begin
          no_fd[LTR_F] = 1'b0;
          no_fd[LTR_D] = 1'b0;
        end
      end
    end else begin : g_no_e
      always_comb no_fd = masked;
    end

    if (IMPL_MASK[LTR_C]) begin : g_c_rule
      always_comb begin
        c_fixed = no_fd;
        if (cur_ext[LTR_C] && !no_fd[LTR_C] && npc_bit1) begin
          c_fixed[LTR_C] = 1'b1;
        end
      end
    end else begin : g_no_c
      always_comb c_fixed = no_fd;
    end
  endgenerate

  assign legal_ext = c_fixed;
  assign accept    = c_fixed[LTR_I] | c_fixed[LTR_E];
endmodule

// File: rtl/isa_ext_store.sv
module isa_ext_store
  import isa_cfg_pkg::*;
#(
  parameter ext_vec_t RESET_EXT = 26'h14112D,
  parameter bit       WRITABLE  = 1'b1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  ext_vec_t wr_val,
  output ext_vec_t ext_q
);
  ext_vec_t ext_d;
  logic     load;

  generate
    if (WRITABLE) begin : g_rw
      assign load = wr_en;
    end else begin : g_ro
      assign load = 1'b0;
      assert_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(ext_q));
    end
  endgenerate

  always_comb begin
    ext_d = ext_q;
    if (load) ext_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= RESET_EXT;
    else        ext_q <= ext_d;
  end
endmodule

// File: rtl/ret_addr_reg.sv
module ret_addr_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_val,
  input  logic            c_on,
  output logic [XLEN-1:0] rd_val
);
  logic [XLEN-1:1] addr_q;
  logic [XLEN-1:1] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (wr_en) addr_d = {wr_val[XLEN-1:2], wr_val[1] & c_on};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign rd_val = {addr_q[XLEN-1:2], addr_q[1] & c_on, 1'b0};
endmodule

// File: rtl/isa_cfg_csr.sv
module isa_cfg_csr
  import isa_cfg_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter logic [11:0] CFG_ADDR  = 12'h301,
  parameter logic [11:0] RET_ADDR  = 12'h341,
  parameter ext_vec_t    IMPL_MASK = 26'h14113D,
  parameter ext_vec_t    RESET_EXT = 26'h14112D,
  parameter bit          WRITABLE  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  input  logic            csr_we,
  output logic [XLEN-1:0] csr_rdata,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] ret_target
);
  localparam logic [1:0]  MXL     = width_code(XLEN);
  localparam int unsigned PAD_W   = XLEN - 2 - EXT_W;
  localparam ext_vec_t    RST_VAL = RESET_EXT & IMPL_MASK;

  logic     rst_meta_n, rst_sync_n;
  logic     hit_cfg, hit_ret;
  ext_vec_t ext_q, legal_ext;
  logic     accept;
  logic [XLEN-1:0] ret_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign hit_cfg = (csr_addr == CFG_ADDR);
  assign hit_ret = (csr_addr == RET_ADDR);

  isa_ext_legalizer #(.IMPL_MASK(IMPL_MASK)) legal_i (
    .cur_ext  (ext_q),
    .req_ext  (csr_wdata[EXT_W-1:0]),
    .npc_bit1 (next_pc[1]),
    .legal_ext(legal_ext),
    .accept   (accept)
  );

  isa_ext_store #(.RESET_EXT(RST_VAL), .WRITABLE(WRITABLE)) store_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (csr_we && hit_cfg && accept),
    .wr_val(legal_ext),
    .ext_q (ext_q)
  );

  ret_addr_reg #(.XLEN(XLEN)) ret_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (csr_we && hit_ret),
    .wr_val(csr_wdata),
    .c_on  (ext_q[LTR_C]),
    .rd_val(ret_rd)
  );

  always_comb begin
    csr_rdata = '0;
    if (hit_cfg)      csr_rdata = {MXL, {PAD_W{1'b0}}, ext_q};
    else if (hit_ret) csr_rdata = ret_rd;
  end

  assign ret_target = ret_rd;

  assert_base_kept_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_q[LTR_I] || ext_q[LTR_E]);

  assert_drop_no_base_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_we && hit_cfg && !(csr_wdata[LTR_I] && IMPL_MASK[LTR_I])
       && !(csr_wdata[LTR_E] && IMPL_MASK[LTR_E])) |=> $stable(ext_q));

  assert_e_excl_fd_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_q[LTR_E] |-> !(ext_q[LTR_F] || ext_q[LTR_D]));

  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_q & ~IMPL_MASK) == '0);

  assert_mxl_fixed_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_cfg |-> csr_rdata[XLEN-1:XLEN-2] == MXL);

  assert_c_refused_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (csr_we && hit_cfg && ext_q[LTR_C] && next_pc[1]) |=> ext_q[LTR_C]);

  assert_bit0_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ret_target[0]);

  assert_ret_align_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ext_q[LTR_C] |-> ret_target[1:0] == 2'b00);
endmodule

// File: tb/isa_cfg_csr_tb_top.sv
`timescale 1ns/1ps
module isa_cfg_csr_tb_top;
  localparam int unsigned XLEN = 32;
  localparam logic [11:0] CFG  = 12'h301;
  localparam logic [11:0] RET  = 12'h341;
  localparam logic [31:0] IMPL = 32'h0014113D;
  localparam logic [31:0] RSTV = 32'h0014112D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic [31:0] csr_wdata = '0;
  logic csr_we = 1'b0;
  logic [31:0] next_pc = '0;
  logic [31:0] rdata, rtgt, rdata_ro, rtgt_ro;

  int checks = 0;
  int bad = 0;
  bit timed_out = 0;

  logic [31:0] m_ext = RSTV;
  logic [31:0] m_ret = '0;

  always #2.5 clk = ~clk;

  isa_cfg_csr dut_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(rdata), .next_pc(next_pc), .ret_target(rtgt));

  isa_cfg_csr #(.WRITABLE(1'b0)) dut_ro_i (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_we(csr_we), .csr_rdata(rdata_ro), .next_pc(next_pc), .ret_target(rtgt_ro));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // behavioural reference of the register pair
  always @(posedge clk) begin
    if (rst_n && csr_we) begin
      if (csr_addr == CFG) begin
        logic [31:0] v;
        v = csr_wdata & IMPL;
        if (v[4]) v = v & ~32'h28;
        if (m_ext[2] && !v[2] && next_pc[1]) v = v | 32'h4;
        if (v[8] || v[4]) m_ext = v;
      end else if (csr_addr == RET) begin
        m_ret = csr_wdata & ~32'h1;
        if (!m_ext[2]) m_ret = m_ret & ~32'h2;
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a == CFG) return 32'h4000_0000 | m_ext;
    if (a == RET) return m_ext[2] ? m_ret : (m_ret & ~32'h2);
    return '0;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !timed_out) begin
      check("R2 per-cycle read", rdata, model_read(csr_addr));
      check("R8 per-cycle return target", rtgt, model_read(RET));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [31:0] npc);
    @(posedge clk); #1;
    csr_addr = a; csr_wdata = d; next_pc = npc; csr_we = 1'b1;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    csr_addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(posedge clk);
        rd(CFG, 32'h4014112D, "R1 reset ext value");
        rd(RET, 32'h0, "R1 reset return address");
        check("R9 read-only reset", rdata_ro, 32'h0);
        rd(CFG, 32'h4014112D, "R9 read-only cfg");
        check("R9 read-only cfg", rdata_ro, 32'h4014112D);

        wr(CFG, 32'hFFFF_FFFF, 32'h0);
        rd(CFG, 32'h40141115, "R5 E clears F and D, R3 width code kept");
        check("R9 write ignored when locked", rdata_ro, 32'h4014112D);

        wr(CFG, 32'h0000_0001, 32'h0);
        rd(CFG, 32'h40141115, "R4 no I or E dropped");

        wr(CFG, 32'h0000_1128, 32'h0000_0002);
        rd(CFG, 32'h4000112C, "R6 C clear refused at misaligned pc, R2 rest applied");

        wr(CFG, 32'h0000_1128, 32'h0000_0004);
        rd(CFG, 32'h40001128, "R6 C clear allowed at aligned pc");

        wr(RET, 32'h8000_0007, 32'h0);
        rd(RET, 32'h80000004, "R7 bits 1:0 stored zero while C clear");
        check("R8 return target aligned", rtgt, 32'h80000004);

        wr(CFG, 32'h0000_112C, 32'h0);
        rd(RET, 32'h80000004, "R7 bit 1 stays zero after C set");

        wr(RET, 32'h0000_1236, 32'h0);
        rd(RET, 32'h00001236, "R7 bit 1 kept with C set");

        wr(CFG, 32'h0000_1128, 32'h0);
        rd(RET, 32'h00001234, "R8 bit 1 hidden while C clear");
        check("R8 return target hides bit 1", rtgt, 32'h00001234);

        wr(CFG, 32'h0000_112C, 32'h0);
        rd(RET, 32'h00001236, "R8 bit 1 shown again with C set");

        wr(12'h300, 32'hFFFF_FFFF, 32'h0);
        rd(CFG, 32'h4000112C, "R10 other write leaves ext");
        rd(RET, 32'h00001236, "R10 other write leaves return address");
        rd(12'h300, 32'h0, "R10 other address reads zero");
        check("R9 read-only after all writes", rdata_ro, 32'h0);
        rd(CFG, 32'h4000112C, "R2 final ext");
        check("R9 read-only final", rdata_ro, 32'h4014112D);
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule